// File: doc/BRIEF.md
# Two-Class Reset Distributor with Sticky Status

This block takes the reset inputs of a hub device and turns them into two internal reset classes. Loss of power-good is the deepest class: it clears every flop in the block, sticky error status included. An active-low platform reset that arrives while power-good stays high is the hard class. It clears the sequencing logic and every ordinary register, but leaves the sticky error status alone so that software can read the cause of the reboot afterwards. A third input requests a processor-only reset. It pulses the front-side-bus resets and leaves the rest of the hub running.

On a hard reset the block drives one active-low reset to each front-side bus and one link-down request to each downstream root port. Taking the link down resets whatever sits behind that port. Both sets of outputs are held for a stretch after the platform reset deasserts and are then released in the same cycle. A small register bank sits inside the block so that its reset behaviour can be observed. It holds sticky error bits in the power-good class and a configuration register in the hard class. All pins are plain control and status levels. No data streams through the block, so it has no valid/ready handshake.

Top module: `rst_domain_ctrl`

## Requirements
- R1: While `pwr_good` is low, `core_rst_n` is 0, every `fsb_rst_n` bit is 0, every `link_down` bit is 1, `err_status` is 0 and `cfg_value` equals `CFG_DEFAULT`. Power-good loss acts asynchronously.
- R2: `plat_rst_n` low with `pwr_good` high drives `core_rst_n` to 0 at once. After `plat_rst_n` (and `pwr_good`) are high, `core_rst_n` returns to 1 at the second rising clock edge.
- R3: `cfg_value` reads `CFG_DEFAULT` whenever `core_rst_n` is 0. A write (`cfg_we` high at a clock edge) stores `cfg_wdata` only if `core_rst_n` was 1 before that edge. Otherwise the write is ignored.
- R4: Each `err_status` bit is set by a 1 on the matching `err_set` bit and cleared by a 1 on the matching `err_clr` bit. When both are 1 in the same cycle, set wins. The bits keep their value through a hard reset and clear only on power-good loss.
- R5: All `link_down` bits and all `fsb_rst_n` bits are asserted together from the moment `plat_rst_n` falls. After the reset inputs go high they stay asserted through the (`HOLD_CYC`+1)-th rising edge and release together at edge `HOLD_CYC`+2, which gives at least `HOLD_CYC` cycles after `core_rst_n` returns.
- R6: A one-cycle `cpu_rst_req` accepted at an edge asserts every `fsb_rst_n` bit for exactly `CPU_PULSE` cycles. During that pulse `link_down`, `core_rst_n`, `err_status` and `cfg_value` are unaffected.
- R7: `cpu_rst_req` is ignored while the R5 hold is in force or a processor pulse is already running. A hard reset arriving mid-pulse cancels the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| pwr_good | input | 1 | Power-good, high when supplies are valid; low clears everything |
| plat_rst_n | input | 1 | Active-low platform (hard) reset request |
| cpu_rst_req | input | 1 | Single-cycle processor-only reset request |
| err_set | input | ERR_W | Per-bit sticky error set strobes |
| err_clr | input | ERR_W | Per-bit sticky error clear strobes |
| cfg_we | input | 1 | Write enable for the non-sticky configuration register |
| cfg_wdata | input | CFG_W | Configuration write data |
| core_rst_n | output | 1 | Synchronised hard-class reset for the hub core, active low |
| fsb_rst_n | output | NUM_FSB | Active-low reset per front-side bus |
| link_down | output | NUM_PORT | Link-down request per downstream root port |
| err_status | output | ERR_W | Sticky error status |
| cfg_value | output | CFG_W | Non-sticky configuration register contents |

## Verification
The assertions assume that `pwr_good` and `plat_rst_n` change independently of the clock and that `cpu_rst_req` is a pulse. They also assume that the status strobes are quiet unless software or hardware means them. The stability property on sticky status only constrains cycles in which both strobe vectors are zero. The bench changes every input one nanosecond after a falling edge, so no input moves at a rising edge. It holds `cpu_rst_req` for exactly one cycle each time and never strobes the error bits in the two cycles while power-good synchronisation is still releasing. Under those conditions the bounded-pulse and hold-ordering properties see only legal request patterns.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

  typedef enum logic {
    PULSE_IDLE = 1'b0,
    PULSE_RUN  = 1'b1
  } pulse_st_e;

  function automatic int cnt_bits(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/rdc_sync.sv
module rdc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic sync_n
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= 1'b0;
        else         chain <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '0;
        else         chain <= {chain[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign sync_n = chain[STAGES-1];

endmodule

// File: rtl/rdc_hold.sv
module rdc_hold #(
  parameter int HOLD_CYC = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic core_n,
  output logic held
);

  localparam int CW = rdc_pkg::cnt_bits(HOLD_CYC);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      remain <= CW'(HOLD_CYC);
    end else if (!core_n) begin
      remain <= CW'(HOLD_CYC);
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign held = !core_n || (remain != '0);

endmodule

// File: rtl/rdc_cpu_pulse.sv
module rdc_cpu_pulse #(
  parameter int CPU_PULSE = 16
) (
  input  logic clk,
  input  logic core_n,
  input  logic held,
  input  logic req,
  output logic active
);

  import rdc_pkg::*;

  localparam int CW = cnt_bits(CPU_PULSE);

  pulse_st_e     state;
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge core_n) begin
    if (!core_n) begin
      state <= PULSE_IDLE;
      left  <= '0;
    end else begin
      unique case (state)
        PULSE_IDLE: begin
          if (req && !held) begin
            state <= PULSE_RUN;
            left  <= CW'(CPU_PULSE);
          end
        end
        PULSE_RUN: begin
          if (left == CW'(1)) begin
            state <= PULSE_IDLE;
          end
          left <= left - 1'b1;
        end
        default: state <= PULSE_IDLE;
      endcase
    end
  end

  assign active = (state == PULSE_RUN);

endmodule

// File: rtl/rdc_regs.sv
module rdc_regs #(
  parameter int          ERR_W       = 8,
  parameter int          CFG_W       = 8,
  parameter logic [CFG_W-1:0] CFG_DEFAULT = '0
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             core_n,
  input  logic [ERR_W-1:0] err_set,
  input  logic [ERR_W-1:0] err_clr,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [ERR_W-1:0] err_status,
  output logic [CFG_W-1:0] cfg_value
);

  // Sticky bits live in the power-good class only.
  generate
    for (genvar b = 0; b < ERR_W; b++) begin : g_sticky
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)          err_status[b] <= 1'b0;
        else if (err_set[b]) err_status[b] <= 1'b1;
        else if (err_clr[b]) err_status[b] <= 1'b0;
      end
    end
  endgenerate

  // Ordinary register follows the hard class.
  always_ff @(posedge clk or negedge core_n) begin
    if (!core_n)     cfg_value <= CFG_DEFAULT;
    else if (cfg_we) cfg_value <= cfg_wdata;
  end

endmodule

// File: rtl/rst_domain_ctrl.sv
module rst_domain_ctrl #(
  parameter int               NUM_FSB     = 2,
  parameter int               NUM_PORT    = 4,
  parameter int               SYNC_STAGES = 2,
  parameter int               HOLD_CYC    = 16,
  parameter int               CPU_PULSE   = 16,
  parameter int               ERR_W       = 8,
  parameter int               CFG_W       = 8,
  parameter logic [CFG_W-1:0] CFG_DEFAULT = 8'hA5
) (
  input  logic                clk,
  input  logic                pwr_good,
  input  logic                plat_rst_n,
  input  logic                cpu_rst_req,
  input  logic [ERR_W-1:0]    err_set,
  input  logic [ERR_W-1:0]    err_clr,
  input  logic                cfg_we,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic                core_rst_n,
  output logic [NUM_FSB-1:0]  fsb_rst_n,
  output logic [NUM_PORT-1:0] link_down,
  output logic [ERR_W-1:0]    err_status,
  output logic [CFG_W-1:0]    cfg_value
);

  logic por_n;
  logic hard_arst_n;
  logic core_n;
  logic held;
  logic cpu_active;

  assign hard_arst_n = pwr_good & plat_rst_n;

  rdc_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk    (clk),
    .arst_n (pwr_good),
    .sync_n (por_n)
  );

  rdc_sync #(.STAGES(SYNC_STAGES)) u_hard_sync (
    .clk    (clk),
    .arst_n (hard_arst_n),
    .sync_n (core_n)
  );

  rdc_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk    (clk),
    .por_n  (por_n),
    .core_n (core_n),
    .held   (held)
  );

  rdc_cpu_pulse #(.CPU_PULSE(CPU_PULSE)) u_cpu (
    .clk    (clk),
    .core_n (core_n),
    .held   (held),
    .req    (cpu_rst_req),
    .active (cpu_active)
  );

  rdc_regs #(
    .ERR_W       (ERR_W),
    .CFG_W       (CFG_W),
    .CFG_DEFAULT (CFG_DEFAULT)
  ) u_regs (
    .clk        (clk),
    .por_n      (por_n),
    .core_n     (core_n),
    .err_set    (err_set),
    .err_clr    (err_clr),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .err_status (err_status),
    .cfg_value  (cfg_value)
  );

  generate
    for (genvar f = 0; f < NUM_FSB; f++) begin : g_fsb
      assign fsb_rst_n[f] = !(held || cpu_active);
    end
    for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
      assign link_down[p] = held;
    end
  endgenerate

  assign core_rst_n = core_n;

endmodule

// File: rtl/rdc_chk.sv
module rdc_chk #(
  parameter int               NUM_FSB     = 2,
  parameter int               NUM_PORT    = 4,
  parameter int               CPU_PULSE   = 16,
  parameter int               ERR_W       = 8,
  parameter int               CFG_W       = 8,
  parameter logic [CFG_W-1:0] CFG_DEFAULT = 8'hA5
) (
  input logic                clk,
  input logic                pwr_good,
  input logic [ERR_W-1:0]    err_set,
  input logic [ERR_W-1:0]    err_clr,
  input logic                core_rst_n,
  input logic [NUM_FSB-1:0]  fsb_rst_n,
  input logic [NUM_PORT-1:0] link_down,
  input logic [ERR_W-1:0]    err_status,
  input logic [CFG_W-1:0]    cfg_value
);

  localparam int PW = rdc_pkg::cnt_bits(CPU_PULSE + 1);

  logic          solo;
  logic [PW-1:0] solo_run;

  assign solo = (fsb_rst_n != '1) && (link_down == '0);

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good)  solo_run <= '0;
    else if (solo)  solo_run <= solo_run + 1'b1;
    else            solo_run <= '0;
  end

  a_r2_core_rst_holds_links: assert property (@(posedge clk) disable iff (!pwr_good)
    !core_rst_n |-> (link_down == '1));

  a_r5_links_uniform: assert property (@(posedge clk) disable iff (!pwr_good)
    (link_down == '0) || (link_down == '1));

  a_r5_links_imply_fsb: assert property (@(posedge clk) disable iff (!pwr_good)
    (link_down != '0) |-> (fsb_rst_n == '0));

  a_r5_hold_outlasts_core: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(core_rst_n) |-> (link_down == '1));

  a_r3_cfg_default: assert property (@(posedge clk) disable iff (!pwr_good)
    !core_rst_n |-> (cfg_value == CFG_DEFAULT));

  a_r4_sticky_stable: assert property (@(posedge clk) disable iff (!pwr_good)
    (err_set == '0 && err_clr == '0) |=> $stable(err_status));

  a_r6_solo_keeps_core: assert property (@(posedge clk) disable iff (!pwr_good)
    solo |-> core_rst_n);

  a_r6_pulse_bounded: assert property (@(posedge clk) disable iff (!pwr_good)
    solo |-> (solo_run < PW'(CPU_PULSE)));

endmodule

bind rst_domain_ctrl rdc_chk #(
  .NUM_FSB     (NUM_FSB),
  .NUM_PORT    (NUM_PORT),
  .CPU_PULSE   (CPU_PULSE),
  .ERR_W       (ERR_W),
  .CFG_W       (CFG_W),
  .CFG_DEFAULT (CFG_DEFAULT)
) u_chk (
  .clk        (clk),
  .pwr_good   (pwr_good),
  .err_set    (err_set),
  .err_clr    (err_clr),
  .core_rst_n (core_rst_n),
  .fsb_rst_n  (fsb_rst_n),
  .link_down  (link_down),
  .err_status (err_status),
  .cfg_value  (cfg_value)
);

// File: tb/sim_rst_domain_ctrl.sv
`timescale 1ns/100ps
module sim_rst_domain_ctrl;

  localparam int         NF   = 2;
  localparam int         NP   = 4;
  localparam int         HOLD = 16;
  localparam int         PUL  = 16;
  localparam logic [7:0] DEF  = 8'hA5;

  logic          clk = 1'b0;
  logic          pwr_good = 1'b0;
  logic          plat_rst_n = 1'b0;
  logic          cpu_rst_req = 1'b0;
  logic [7:0]    err_set = '0;
  logic [7:0]    err_clr = '0;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_wdata = '0;
  logic          core_rst_n;
  logic [NF-1:0] fsb_rst_n;
  logic [NP-1:0] link_down;
  logic [7:0]    err_status;
  logic [7:0]    cfg_value;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rst_domain_ctrl #(
    .NUM_FSB(NF), .NUM_PORT(NP), .HOLD_CYC(HOLD), .CPU_PULSE(PUL),
    .ERR_W(8), .CFG_W(8), .CFG_DEFAULT(DEF)
  ) u0 (
    .clk(clk), .pwr_good(pwr_good), .plat_rst_n(plat_rst_n),
    .cpu_rst_req(cpu_rst_req), .err_set(err_set), .err_clr(err_clr),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .core_rst_n(core_rst_n),
    .fsb_rst_n(fsb_rst_n), .link_down(link_down),
    .err_status(err_status), .cfg_value(cfg_value)
  );

  // Behavioural reference: counts of edges seen with the inputs high.
  int         hard_edges = 0;
  int         pg_edges = 0;
  int         cpu_left = 0;
  logic [7:0] err_m = '0;
  logic [7:0] cfg_m = DEF;

  function automatic int eff_hard();
    return (pwr_good && plat_rst_n) ? hard_edges : 0;
  endfunction
  function automatic int eff_pg();
    return pwr_good ? pg_edges : 0;
  endfunction

  always @(posedge clk) begin
    int  nb;
    int  mb;
    bit  hold_b;
    nb = eff_hard();
    mb = eff_pg();
    hold_b = nb < HOLD + 2;
    if (nb < 2) cfg_m = DEF;
    else if (cfg_we) cfg_m = cfg_wdata;
    if (nb < 2) cpu_left = 0;
    else if (cpu_left != 0) cpu_left--;
    else if (cpu_rst_req && !hold_b) cpu_left = PUL;
    if (mb < 2) err_m = '0;
    else err_m = (err_m & ~err_clr) | err_set;
    hard_edges = (pwr_good && plat_rst_n) ? ((nb < 1000) ? nb + 1 : nb) : 0;
    pg_edges   = pwr_good ? ((mb < 1000) ? mb + 1 : mb) : 0;
    cycles++;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference, away from the rising edge.
  always @(negedge clk) begin
    int  n;
    bit  hold_e;
    bit  cpu_e;
    if (!done) begin
      n = eff_hard();
      hold_e = n < HOLD + 2;
      cpu_e  = (n >= 2) && (cpu_left != 0);
      chk("R2", "core_rst_n", 32'(core_rst_n), 32'(n >= 2));
      chk("R5", "link_down", 32'(link_down), hold_e ? 32'({NP{1'b1}}) : 32'h0);
      chk("R5 R6 R7", "fsb_rst_n", 32'(fsb_rst_n),
          (hold_e || cpu_e) ? 32'h0 : 32'({NF{1'b1}}));
      chk("R1 R4", "err_status", 32'(err_status), (eff_pg() < 2) ? 32'h0 : 32'(err_m));
      chk("R3", "cfg_value", 32'(cfg_value), (n < 2) ? 32'(DEF) : 32'(cfg_m));
    end
  end

  task automatic idle(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); #1;
      cpu_rst_req = 1'b0; err_set = '0; err_clr = '0; cfg_we = 1'b0;
    end
  endtask

  task automatic cyc();
    @(negedge clk); #1;
  endtask

  initial begin
    // R1: power absent
    idle(4);
    @(negedge clk); #0.5;
    chk("R1", "reset core", 32'(core_rst_n), 32'h0);
    chk("R1", "reset fsb", 32'(fsb_rst_n), 32'h0);
    chk("R1", "reset link", 32'(link_down), 32'({NP{1'b1}}));
    chk("R1", "reset cfg", 32'(cfg_value), 32'(DEF));
    #0.5;
    pwr_good = 1'b1;
    idle(3);
    plat_rst_n = 1'b1;
    idle(25);

    // R3 R4: register bank
    cyc(); err_set = 8'h05; cfg_we = 1'b1; cfg_wdata = 8'h3C;
    idle(2);
    chk("R4", "sticky set", 32'(err_status), 32'h05);
    chk("R3", "cfg write", 32'(cfg_value), 32'h3C);

    // R6 R7: processor pulse, repeat request inside it
    cyc(); cpu_rst_req = 1'b1;
    idle(5);
    cyc(); cpu_rst_req = 1'b1;
    idle(20);
    chk("R6", "regs kept", 32'(cfg_value), 32'h3C);

    // R4: clear and set-wins
    cyc(); err_set = 8'h80; err_clr = 8'h01;
    cyc(); err_set = 8'h10; err_clr = 8'h10;
    idle(2);
    chk("R4", "set wins", 32'(err_status), 32'h94);

    // Hard reset: writes ignored, sticky captured, request ignored
    cyc(); plat_rst_n = 1'b0;
    idle(1);
    cyc(); cfg_we = 1'b1; cfg_wdata = 8'h77; err_set = 8'h20;
    cyc(); cpu_rst_req = 1'b1;
    idle(2);
    plat_rst_n = 1'b1;
    idle(4);
    cyc(); cpu_rst_req = 1'b1;
    idle(25);
    chk("R4", "sticky survives", 32'(err_status), 32'hB4);
    chk("R3", "cfg default", 32'(cfg_value), 32'(DEF));
    chk("R7", "ignored in hold", 32'(fsb_rst_n), 32'({NF{1'b1}}));

    // R7: hard reset cancels a running pulse
    cyc(); cpu_rst_req = 1'b1;
    idle(3);
    plat_rst_n = 1'b0;
    idle(2);
    plat_rst_n = 1'b1;
    idle(25);

    // R1: power loss clears sticky status
    pwr_good = 1'b0;
    idle(3);
    chk("R1", "sticky cleared", 32'(err_status), 32'h0);
    pwr_good = 1'b1;
    idle(25);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<5000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule